// File: doc/BRIEF.md
# Cache-Line Burst Size Selector

This block sits inside a bus-master DMA read engine. It divides a read job into bus requests. A job is a start address, a byte count, the programmed cache line size in bytes and the bus mode. When at least one whole line's worth of data is left, the block asks for the largest whole number of cache lines that fits in what remains. A tail shorter than a line goes out afterwards as its own request. When the line size is unusable, the whole remainder goes out as a single plain request.

Each request is offered to the bus-interface state machine with a valid strobe. The strobe carries a command code, a byte length and an address. These stay steady until the state machine acknowledges them. On acknowledge the block advances its address and remaining count by the granted length. It works out the next request in the cycle that follows. Conventional bus mode uses the plain-read and multiple-line-read commands. Extended mode uses the block-read command for every request.

Top module: `burst_size_selector`

## Requirements
- R1: A `start_i` pulse with a nonzero `job_bytes_i`, seen while `busy_o` is low, latches the address, byte count, line size and mode. After that edge `busy_o` is high and `req_valid_o` is low. After the next edge `req_valid_o` is high. A start with zero bytes, or one seen while busy, is ignored.
- R2: A line size is usable only when it is a nonzero power of two. With an unusable line size, the job goes out as one request whose length is the whole byte count.
- R3: With a usable line size L and R bytes remaining, where R >= L, the request length is the largest multiple of L that is not above R.
- R4: A remainder shorter than L goes out as a separate request whose length equals that remainder.
- R5: Command codes are 4'h6 for a plain read and 4'hC for a multiple-line read, both in conventional mode (`ext_mode_i`=0). In extended mode every request carries 4'hE. No other code is ever offered, and 4'h6 never appears in extended mode.
- R6: While `req_valid_o` is high and `ack_i` is low, the command, length and address stay unchanged, even if a new start arrives.
- R7: An acknowledge advances the address and the remaining count by the offered length. `req_valid_o` is low in the next cycle and high again in the one after, if bytes remain. Once the count reaches zero, `busy_o` and `req_valid_o` are both low.
- R8: After reset, `req_valid_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Job start pulse |
| job_addr_i | input | ADDR_W | Start address of the job |
| job_bytes_i | input | CNT_W | Byte count of the job |
| line_bytes_i | input | LINE_W | Cache line size in bytes |
| ext_mode_i | input | 1 | 1 = extended bus mode, 0 = conventional |
| ack_i | input | 1 | Acknowledge of the offered request |
| req_valid_o | output | 1 | Request offered |
| req_cmd_o | output | 4 | Read command code |
| req_addr_o | output | ADDR_W | Request start address |
| req_len_o | output | CNT_W | Request length in bytes |
| busy_o | output | 1 | Job in progress |

## Verification
The bench sweeps every line size from 0 to 33 against every byte count from 0 to 67, in both modes, plus a few large jobs. This separates powers of two from unusable sizes, and jobs below, at, and above one line. It also covers counts that are exact line multiples from those that leave a tail. Acknowledges come after a delay that varies by job, so the hold-steady rule is tried at several wait lengths. Starts are injected during a hold and with a zero byte count, to show that both are ignored.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

  typedef enum logic [3:0] {
    CMD_RD       = 4'h6,
    CMD_RD_MULTI = 4'hC,
    CMD_RD_BLOCK = 4'hE
  } rd_cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PICK  = 2'd1,
    SQ_OFFER = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bsel_line_decode.sv
module bsel_line_decode #(
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line,
  output logic              line_ok
);

  function automatic logic is_pow2(input logic [LINE_W-1:0] v);
    return (v != '0) && ((v & (v - LINE_W'(1))) == '0);
  endfunction

  assign line_ok = is_pow2(line);

  assert_line_usable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_ok |-> ($countones(line) == 1))
    else $error("line flagged usable but not a single set bit");

  assert_line_unusable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_ok |-> ($countones(line) != 1))
    else $error("power-of-two line flagged unusable");

endmodule

// File: rtl/bsel_pick.sv
module bsel_pick
  import bsel_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rem,
  input  logic [LINE_W-1:0] line,
  input  logic              line_ok,
  input  logic              ext,
  output logic [CNT_W-1:0]  pick_len,
  output rd_cmd_e           pick_cmd
);

  // bytes covered by whole lines: clear the sub-line offset bits
  function automatic logic [CNT_W-1:0] whole_lines(input logic [CNT_W-1:0] r,
                                                   input logic [LINE_W-1:0] l);
    logic [CNT_W-1:0] mask;
    mask = CNT_W'(l) - CNT_W'(1);
    return r & ~mask;
  endfunction

  logic [CNT_W-1:0] lines_len;
  logic             use_lines;

  assign lines_len = whole_lines(rem, line);
  assign use_lines = line_ok && (lines_len != '0);

  always_comb begin
    if (use_lines) begin
      pick_len = lines_len;
      pick_cmd = ext ? CMD_RD_BLOCK : CMD_RD_MULTI;
    end else begin
      pick_len = rem;
      pick_cmd = ext ? CMD_RD_BLOCK : CMD_RD;
    end
  end

  assert_len_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rem != '0) |-> ((pick_len != '0) && (pick_len <= rem)))
    else $error("picked length outside remaining count");

  assert_multi_largest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ok && pick_len != rem) |-> ((rem - pick_len) < CNT_W'(line)))
    else $error("burst is not the largest line multiple");

  assert_unusable_whole_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_ok) |-> (pick_len == rem))
    else $error("unusable line size split the job");

endmodule

// File: rtl/bsel_seq.sv
module bsel_seq
  import bsel_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [CNT_W-1:0]  job_bytes,
  input  logic [LINE_W-1:0] job_line,
  input  logic              job_ext,
  input  logic              ack,
  input  logic [CNT_W-1:0]  pick_len,
  input  rd_cmd_e           pick_cmd,
  output logic [CNT_W-1:0]  cur_rem,
  output logic [LINE_W-1:0] cur_line,
  output logic              cur_ext,
  output logic              req_valid,
  output logic [3:0]        req_cmd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CNT_W-1:0]  req_len,
  output logic              busy
);

  seq_state_e        state;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  logic              ext_q;
  rd_cmd_e           cmd_q;
  logic [CNT_W-1:0]  len_q;

  // named events for the checks below
  logic             evt_accept;
  logic             evt_take;
  logic             evt_last;
  logic [CNT_W-1:0] rem_after;

  assign evt_accept = start && (state == SQ_IDLE) && (job_bytes != '0);
  assign evt_take   = (state == SQ_OFFER) && ack;
  assign rem_after  = rem_q - len_q;
  assign evt_last   = evt_take && (rem_after == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      rem_q  <= '0;
      addr_q <= '0;
      line_q <= '0;
      ext_q  <= 1'b0;
      cmd_q  <= CMD_RD;
      len_q  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (evt_accept) begin
            rem_q  <= job_bytes;
            addr_q <= job_addr;
            line_q <= job_line;
            ext_q  <= job_ext;
            state  <= SQ_PICK;
          end
        end
        SQ_PICK: begin
          cmd_q <= pick_cmd;
          len_q <= pick_len;
          state <= SQ_OFFER;
        end
        SQ_OFFER: begin
          if (evt_take) begin
            rem_q  <= rem_after;
            addr_q <= addr_q + ADDR_W'(len_q);
            state  <= evt_last ? SQ_IDLE : SQ_PICK;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign cur_rem   = rem_q;
  assign cur_line  = line_q;
  assign cur_ext   = ext_q;
  assign req_valid = (state == SQ_OFFER);
  assign req_cmd   = cmd_q;
  assign req_addr  = addr_q;
  assign req_len   = len_q;
  assign busy      = (state != SQ_IDLE);

  assert_first_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (busy && !req_valid))
    else $error("accepted job offered too early");

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid)
    else $error("request offered while idle");

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ack) |=> (req_valid && $stable(req_cmd) && $stable(req_len)
                             && $stable(req_addr)))
    else $error("offered request changed before acknowledge");

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ack) |=> !req_valid)
    else $error("no idle cycle after acknowledge");

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ack) |=> (req_addr == $past(req_addr) + ADDR_W'($past(req_len))))
    else $error("address did not advance by granted length");

  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last |=> !busy)
    else $error("busy after last burst");

  assert_cmd_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_cmd == 4'h6 || req_cmd == 4'hC || req_cmd == 4'hE))
    else $error("illegal command offered");

  assert_plain_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 4'h6) |-> !ext_q)
    else $error("plain read in extended mode");

endmodule

// File: rtl/burst_size_selector.sv
module burst_size_selector
  import bsel_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] job_addr_i,
  input  logic [CNT_W-1:0]  job_bytes_i,
  input  logic [LINE_W-1:0] line_bytes_i,
  input  logic              ext_mode_i,
  input  logic              ack_i,
  output logic              req_valid_o,
  output logic [3:0]        req_cmd_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [CNT_W-1:0]  req_len_o,
  output logic              busy_o
);

  logic [CNT_W-1:0]  cur_rem;
  logic [LINE_W-1:0] cur_line;
  logic              cur_ext;
  logic              line_ok;
  logic [CNT_W-1:0]  pick_len;
  rd_cmd_e           pick_cmd;

  bsel_line_decode #(.LINE_W(LINE_W)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .line    (cur_line),
    .line_ok (line_ok)
  );

  bsel_pick #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .rem      (cur_rem),
    .line     (cur_line),
    .line_ok  (line_ok),
    .ext      (cur_ext),
    .pick_len (pick_len),
    .pick_cmd (pick_cmd)
  );

  bsel_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .job_addr  (job_addr_i),
    .job_bytes (job_bytes_i),
    .job_line  (line_bytes_i),
    .job_ext   (ext_mode_i),
    .ack       (ack_i),
    .pick_len  (pick_len),
    .pick_cmd  (pick_cmd),
    .cur_rem   (cur_rem),
    .cur_line  (cur_line),
    .cur_ext   (cur_ext),
    .req_valid (req_valid_o),
    .req_cmd   (req_cmd_o),
    .req_addr  (req_addr_o),
    .req_len   (req_len_o),
    .busy      (busy_o)
  );

endmodule

// File: tb/burst_size_selector_bench.sv
module burst_size_selector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] job_addr_i = '0;
  logic [15:0] job_bytes_i = '0;
  logic [7:0]  line_bytes_i = '0;
  logic        ext_mode_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        req_valid_o;
  logic [3:0]  req_cmd_o;
  logic [31:0] req_addr_o;
  logic [15:0] req_len_o;
  logic        busy_o;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  burst_size_selector u_burst_size_selector (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .job_addr_i   (job_addr_i),
    .job_bytes_i  (job_bytes_i),
    .line_bytes_i (line_bytes_i),
    .ext_mode_i   (ext_mode_i),
    .ack_i        (ack_i),
    .req_valid_o  (req_valid_o),
    .req_cmd_o    (req_cmd_o),
    .req_addr_o   (req_addr_o),
    .req_len_o    (req_len_o),
    .busy_o       (busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit usable(input int l);
    for (int k = 0; k < 8; k++)
      if (l == (1 << k)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_job(input int addr, input int n, input int line, input bit ext);
    int lens[2];
    int cmds[2];
    int nb;
    int exp_addr;
    int big;
    int tail;
    int d;
    bit inject;
    @(negedge clk);
    start_i = 1'b1; job_addr_i = addr; job_bytes_i = n[15:0];
    line_bytes_i = line[7:0]; ext_mode_i = ext;
    @(negedge clk);
    start_i = 1'b0;
    if (n == 0) begin
      // R1: zero-byte start is ignored
      chk(!busy_o && !req_valid_o, "R1 zero-byte start ignored", {busy_o, req_valid_o}, 0);
      return;
    end
    chk(busy_o && !req_valid_o, "R1 busy without offer after start", {busy_o, req_valid_o}, 2);
    @(negedge clk);
    chk(req_valid_o, "R1 first offer", req_valid_o, 1);
    big  = usable(line) ? (n / line) * line : 0;
    tail = n - big;
    nb = 0;
    if (big != 0) begin lens[nb] = big;  cmds[nb] = ext ? 'hE : 'hC; nb++; end
    if (tail != 0) begin lens[nb] = tail; cmds[nb] = ext ? 'hE : 'h6; nb++; end
    exp_addr = addr;
    for (int b = 0; b < nb; b++) begin
      chk(req_valid_o, "R7 offer present", req_valid_o, 1);
      chk(req_cmd_o == cmds[b][3:0], "R5 command code", req_cmd_o, cmds[b]);
      if (!usable(line))
        chk(req_len_o == lens[b][15:0], "R2 whole job in one request", req_len_o, lens[b]);
      else if (cmds[b] == 'hC || (ext && b == 0 && big != 0))
        chk(req_len_o == lens[b][15:0], "R3 largest line multiple", req_len_o, lens[b]);
      else
        chk(req_len_o == lens[b][15:0], "R4 tail length", req_len_o, lens[b]);
      chk(req_addr_o == exp_addr, "R7 request address", req_addr_o, exp_addr);
      d = (n + line + b) % 3;
      inject = (d != 0) && (n % 5 == 0);
      if (inject) begin
        start_i = 1'b1; job_bytes_i = 16'h0055; job_addr_i = 32'hDEAD0000;
      end
      for (int w = 0; w < d; w++) begin
        @(negedge clk);
        start_i = 1'b0;
        chk(req_valid_o && req_cmd_o == cmds[b][3:0] && req_len_o == lens[b][15:0]
            && req_addr_o == exp_addr, "R6 request held until ack", req_len_o, lens[b]);
      end
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      exp_addr = exp_addr + lens[b];
      if (b == nb - 1) begin
        chk(!busy_o && !req_valid_o, "R7 idle after last burst", {busy_o, req_valid_o}, 0);
      end else begin
        chk(busy_o && !req_valid_o, "R7 gap cycle after ack", {busy_o, req_valid_o}, 2);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid_o && !busy_o, "R8 reset state", {busy_o, req_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid_o && !busy_o, "R8 idle after reset release", {busy_o, req_valid_o}, 0);
    for (int e = 0; e < 2; e++)
      for (int l = 0; l < 34; l++)
        for (int n = 0; n < 68; n++)
          run_job(32'h1000_0000 + (l << 12) + n * 4, n, l, e[0]);
    run_job(32'h2000_0000, 1000, 128, 1'b0);
    run_job(32'h3000_0000, 65535, 64, 1'b0);
    run_job(32'h4000_0000, 65535, 64, 1'b1);
    run_job(32'h5000_0000, 777, 200, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule